// File: doc/BRIEF.md
# Flash Block Lock Manager

This block holds the write-protection state of every erase block in a boot-block flash array of eight small parameter blocks at the bottom of the address space followed by sixty-three large main blocks. Each block carries two state bits: a lock bit and a lock-down bit. A command front end sends lock, unlock and lock-down requests tagged with a 21-bit word address. The block turns the address into a block index and updates only the addressed block. A hardware write-protect input, active low, decides whether a locked-down block can still be changed.

A second, independent address port answers queries with no clock delay. It returns the two state bits of the addressed block for signature reads, and a permit flag that the command front end uses to allow or refuse program and erase. The command port has no back-pressure: a request presented with `cmd_valid` high is taken on that rising clock edge, every cycle. Lock and unlock requests act the same whatever the array is doing, including while an erase is suspended.

Top module: `flash_lock_mgr`

## Requirements
- R1: While reset is asserted and right after it is released, every block reports status 2'b01 (bit 0 = locked, bit 1 = locked-down) and permit 0.
- R2: A lock request (cmd_op 2'b01) sets bit 0 of the addressed block, and any mix of blocks can be locked at once without one request touching another block.
- R3: An unlock request (cmd_op 2'b10) clears bit 0 of the addressed block, unless R5 applies.
- R4: A lock-down request (cmd_op 2'b11) sets both bits of the addressed block, whatever the level of wp_n. cmd_op 2'b00 changes nothing.
- R5: While wp_n is low, a block whose bit 1 is set ignores lock and unlock requests, so its status stays the same.
- R6: While wp_n is high, lock-down is overridden: an unlock request on a locked-down block clears bit 0 and leaves bit 1 set (status 2'b10).
- R7: A reset returns every locked-down block to plain locked (2'b01).
- R8: qry_permit is 1 exactly when bit 0 of the queried block is 0, whatever bit 1 and wp_n are, and it follows qry_addr in the same cycle.
- R9: The block index is addr[14:12] when addr[20:15] is zero (parameter blocks 0 to 7), and 7 + addr[20:15] otherwise (main blocks 8 to 70).
- R10: A request changes the state on the rising edge that takes it. A query of the same block in that cycle still shows the old state, and the new state shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low; forces every block to locked |
| wp_n | input | 1 | Write-protect pin, low keeps locked-down blocks frozen |
| cmd_valid | input | 1 | Request present this cycle, always accepted |
| cmd_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_addr | input | 21 | Word address that selects the target block |
| qry_addr | input | 21 | Word address of the block being queried |
| qry_permit | output | 1 | 1 when program or erase of the queried block is allowed |
| qry_status | output | 2 | Bit 0 locked, bit 1 locked-down, of the queried block |

## Verification
A state update and a query can land on the same block in the same cycle, because the request port and the query port are separate. The bench provokes this directly by locking block 70 while querying it, and in the random phase about a quarter of the steps point the query at the commanded address. Before the clock edge, the query must show the state from before the request. In the next cycle it must show the state that the bench's own model computes for the request, the wp_n level and the prior state.

// File: rtl/flm_pkg.sv
package flm_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_LOCK     = 2'b01,
    OP_UNLOCK   = 2'b10,
    OP_LOCKDOWN = 2'b11
  } lock_op_e;

  typedef struct packed {
    logic down;
    logic locked;
  } blk_state_t;
endpackage

// File: rtl/flm_blk_index.sv
module flm_blk_index #(
  parameter int ADDR_W    = 21,
  parameter int MAIN_LSB  = 15,
  parameter int PARAM_LSB = 12,
  parameter int IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int PARAM_BLKS = 2 ** (MAIN_LSB - PARAM_LSB);
  localparam int NUM_BLKS   = PARAM_BLKS - 1 + 2 ** (ADDR_W - MAIN_LSB);

  logic [ADDR_W-MAIN_LSB-1:0]   main_sel;
  logic [MAIN_LSB-PARAM_LSB-1:0] param_sel;

  assign main_sel  = addr[ADDR_W-1:MAIN_LSB];
  assign param_sel = addr[MAIN_LSB-1:PARAM_LSB];

  always_comb begin
    if (main_sel == '0) idx = IDX_W'(param_sel);
    else                idx = IDX_W'(main_sel) + IDX_W'(PARAM_BLKS - 1);
  end

  always_comb begin
    if (!$isunknown(addr))
      AST_IDX_IN_RANGE: assert (int'(idx) < NUM_BLKS); // R9
  end
endmodule

// File: rtl/flm_lock_cell.sv
module flm_lock_cell
  import flm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       hit,
  input  lock_op_e   op,
  output blk_state_t state
);
  blk_state_t st_q;
  logic       frozen;

  assign frozen = st_q.down && !wp_n;
  assign state  = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.locked <= 1'b1;
      st_q.down   <= 1'b0;
    end else if (hit) begin
      unique case (op)
        OP_LOCK:     if (!frozen) st_q.locked <= 1'b1;
        OP_UNLOCK:   if (!frozen) st_q.locked <= 1'b0;
        OP_LOCKDOWN: begin
          st_q.locked <= 1'b1;
          st_q.down   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st_q.down && !wp_n && op != OP_LOCKDOWN) |=> $stable(st_q)); // R5
  AST_LOCKDOWN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_LOCKDOWN) |=> (st_q.locked && st_q.down)); // R4
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == OP_UNLOCK && (wp_n || !st_q.down)) |=> !st_q.locked); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(st_q)); // R2
  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.down |=> st_q.down); // R6
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
  import flm_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int MAIN_LSB  = 15,
  parameter int PARAM_LSB = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_permit,
  output logic [1:0]        qry_status
);
  localparam int PARAM_BLKS = 2 ** (MAIN_LSB - PARAM_LSB);
  localparam int NUM_BLKS   = PARAM_BLKS - 1 + 2 ** (ADDR_W - MAIN_LSB);
  localparam int IDX_W      = $clog2(NUM_BLKS);

  logic [IDX_W-1:0]    cmd_idx;
  logic [IDX_W-1:0]    qry_idx;
  logic [NUM_BLKS-1:0] hit;
  blk_state_t          blk_st [NUM_BLKS];
  blk_state_t          sel_st;
  lock_op_e            op;

  assign op = lock_op_e'(cmd_op);

  flm_blk_index #(.ADDR_W(ADDR_W), .MAIN_LSB(MAIN_LSB), .PARAM_LSB(PARAM_LSB), .IDX_W(IDX_W))
    u_cmd_dec (.addr(cmd_addr), .idx(cmd_idx));
  flm_blk_index #(.ADDR_W(ADDR_W), .MAIN_LSB(MAIN_LSB), .PARAM_LSB(PARAM_LSB), .IDX_W(IDX_W))
    u_qry_dec (.addr(qry_addr), .idx(qry_idx));

  for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
    assign hit[g] = cmd_valid && (cmd_idx == IDX_W'(g));
    flm_lock_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wp_n  (wp_n),
      .hit   (hit[g]),
      .op    (op),
      .state (blk_st[g])
    );
  end

  always_comb begin
    sel_st = '{down: 1'b0, locked: 1'b1};
    for (int i = 0; i < NUM_BLKS; i++)
      if (qry_idx == IDX_W'(i)) sel_st = blk_st[i];
  end

  assign qry_status = {sel_st.down, sel_st.locked};
  assign qry_permit = !sel_st.locked;

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R2
  AST_VALID_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(hit) == 1); // R9
endmodule

// File: tb/test_flash_lock_mgr.sv
module test_flash_lock_mgr;
  localparam int NB = 71;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [20:0] cmd_addr = '0;
  logic [20:0] qry_addr = '0;
  logic        qry_permit;
  logic [1:0]  qry_status;

  int n_chk = 0;
  int n_bad = 0;
  logic m_lk [NB];
  logic m_dn [NB];

  always #4 clk = ~clk;

  flash_lock_mgr i_flash_lock_mgr (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .qry_addr(qry_addr),
    .qry_permit(qry_permit), .qry_status(qry_status)
  );

  function automatic int blk_of(input logic [20:0] a);
    if (a[20:15] == 6'd0) return int'(a[14:12]);
    return 7 + int'(a[20:15]);
  endfunction

  task automatic expect_blk(input string tag, input logic [20:0] a);
    logic [1:0] ex;
    int b;
    b = blk_of(a);
    ex = {m_dn[b], m_lk[b]};
    n_chk++;
    if (qry_status !== ex || qry_permit !== !ex[0]) begin
      n_bad++;
      $display("FAIL %s addr=%h status/permit=%b/%b expected %b/%b",
               tag, a, qry_status, qry_permit, ex, !ex[0]);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_lk[i] = 1'b1; m_dn[i] = 1'b0; end
  endtask

  task automatic model_apply(input logic v, input logic [1:0] op, input logic [20:0] a, input logic wp);
    int b;
    logic frz;
    b = blk_of(a);
    frz = m_dn[b] && !wp;
    if (!v) return;
    case (op)
      2'b01: if (!frz) m_lk[b] = 1'b1;
      2'b10: if (!frz) m_lk[b] = 1'b0;
      2'b11: begin m_lk[b] = 1'b1; m_dn[b] = 1'b1; end
      default: ;
    endcase
  endtask

  // one cycle: drive, check the query before the edge, advance the model at the edge
  task automatic step(input string tag, input logic v, input logic [1:0] op,
                      input logic [20:0] a, input logic [20:0] q, input logic wp);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; qry_addr = q; wp_n = wp;
    #1;
    expect_blk(tag, q);
    @(posedge clk);
    model_apply(v, op, a, wp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    model_reset();
    @(negedge clk);
    #1;
    expect_blk("R1", 21'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: every block locked after reset
    for (int i = 0; i < 8; i++) step("R1", 1'b0, 2'b00, '0, 21'(i) << 12, 1'b0);
    for (int i = 1; i < 64; i++) step("R1", 1'b0, 2'b00, '0, 21'(i) << 15, 1'b0);
    // R9 / R3: boundary addresses
    step("R3", 1'b1, 2'b10, 21'h000000, 21'h000FFF, 1'b0);
    step("R9", 1'b0, 2'b00, '0, 21'h000FFF, 1'b0);
    step("R9", 1'b0, 2'b00, '0, 21'h001000, 1'b0);
    step("R3", 1'b1, 2'b10, 21'h008000, 21'h007FFF, 1'b0);
    step("R9", 1'b0, 2'b00, '0, 21'h00FFFF, 1'b0);
    step("R9", 1'b0, 2'b00, '0, 21'h007FFF, 1'b0);
    step("R9", 1'b1, 2'b10, 21'h1F8000, 21'h1F7FFF, 1'b0);
    step("R9", 1'b0, 2'b00, '0, 21'h1FFFFF, 1'b0);
    // R2: relock block 0, block 8 stays unlocked
    step("R2", 1'b1, 2'b01, 21'h000123, 21'h008000, 1'b0);
    step("R2", 1'b0, 2'b00, '0, 21'h000000, 1'b0);
    step("R2", 1'b0, 2'b00, '0, 21'h00C000, 1'b0);
    // R4: no-op code, then lock-down block 8
    step("R4", 1'b1, 2'b00, 21'h008000, 21'h008000, 1'b1);
    step("R4", 1'b1, 2'b11, 21'h008000, 21'h008000, 1'b1);
    step("R4", 1'b0, 2'b00, '0, 21'h008000, 1'b1);
    // R5: frozen while wp_n low
    step("R5", 1'b1, 2'b10, 21'h008000, 21'h008000, 1'b0);
    step("R5", 1'b0, 2'b00, '0, 21'h008000, 1'b0);
    // R6 / R8: override with wp_n high, permit despite down bit
    step("R6", 1'b1, 2'b10, 21'h008000, 21'h008000, 1'b1);
    step("R6", 1'b0, 2'b00, '0, 21'h008000, 1'b1);
    step("R8", 1'b0, 2'b00, '0, 21'h008000, 1'b0);
    step("R5", 1'b1, 2'b01, 21'h008000, 21'h008000, 1'b0);
    step("R5", 1'b0, 2'b00, '0, 21'h008000, 1'b0);
    // R10: request and query on block 70 in the same cycle
    step("R10", 1'b1, 2'b01, 21'h1FC000, 21'h1FC000, 1'b0);
    step("R10", 1'b0, 2'b00, '0, 21'h1FC000, 1'b0);
    // R7: reset clears lock-down
    do_reset();
    step("R7", 1'b0, 2'b00, '0, 21'h008000, 1'b0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [20:0] a, q;
      logic [1:0]  op;
      logic        v, wp;
      a  = 21'($urandom) & 21'h1FFFFF;
      if ($urandom_range(1, 0) == 1) a[20:15] = 6'($urandom_range(1, 0));
      q  = ($urandom_range(3, 0) == 0) ? a : (21'($urandom) & 21'h1FFFFF);
      if ($urandom_range(1, 0) == 1) q[20:15] = 6'($urandom_range(1, 0));
      op = 2'($urandom_range(3, 0));
      v  = ($urandom_range(4, 0) != 0);
      wp = ($urandom_range(2, 0) == 0);
      step((a == q) ? "R10" : "R8", v, op, a, q, wp);
      if ($urandom_range(499, 0) == 0) do_reset();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule